// File: doc/BRIEF.md
# Dual-Thread Idle Frequency and Voltage Controller

This block sits beside a physical core that runs two hardware threads. It watches one halt flag per thread. While either thread runs, it requests the nominal clock-multiplier code and the nominal voltage code. When every thread is halted at the same time, it drops the multiplier request at once to a fixed minimum. It then lowers the voltage request one code at a time toward a low target. No software command starts or ends this sequence.

When any thread wakes, the block turns back. The voltage request climbs one code per step interval from the code it has reached. A wake during the descent therefore turns the ramp around without starting it again. Once the voltage is back at nominal and a settle interval has run out, the multiplier returns to nominal. Clearing the enable input forces both requests to nominal in the same cycle and keeps them there.

The multiplier request only ever takes two values. The voltage request moves through every code between its end points. Both step interval and settle interval are parameters given in clock cycles.

Top module: `idle_fv_ctrl`

## Requirements
- R1: While enabled and at least one thread is not halted, the state stays active (status 2'b00), fid_o equals fid_nom_i and vid_o equals vid_nom_i.
- R2: In the active state with enable set and all halt bits set, the next cycle reports status 2'b01 with fid_o equal to fid_min_i and vid_o still equal to vid_nom_i.
- R3: While entering, vid_o falls by exactly one code every STEP_CYCLES cycles and never goes below vid_low_i. The cycle after it equals vid_low_i, the status becomes low-power (2'b10). With N = vid_nom_i - vid_low_i, low-power is reported STEP_CYCLES*N + 1 cycles after entering is first reported.
- R4: fid_o only ever equals fid_nom_i or fid_min_i.
- R5: A wake (any halt bit clear) while entering or in low-power gives status 2'b11 on the next cycle, with vid_o unchanged. vid_o then rises by one code every STEP_CYCLES cycles, and fid_o stays at fid_min_i.
- R6: In the exiting state, fid_o returns to fid_nom_i exactly SETTLE_CYCLES cycles after vid_o first equals vid_nom_i, and the status goes back to 2'b00 at the same time.
- R7: With enable_i low, fid_o and vid_o equal the nominal inputs and the status reads 2'b00 in the same cycle. Halt flags are ignored while enable_i stays low.
- R8: If all threads halt again while exiting, the next cycle reports entering (2'b01) with vid_o unchanged. The descent then continues from that code.
- R9: After reset the status is 2'b00 and the outputs are nominal.
- R10: Status encoding: 2'b00 active, 2'b01 entering, 2'b10 low-power, 2'b11 exiting. Higher VID codes mean higher voltage.
- R11: While enabled, the internal voltage code changes by at most one code per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | NUM_THREADS | Per-thread halted flag |
| enable_i | input | 1 | Allows automatic idle entry when set |
| fid_nom_i | input | FID_W | Nominal multiplier code |
| fid_min_i | input | FID_W | Idle multiplier code |
| vid_nom_i | input | VID_W | Nominal voltage code |
| vid_low_i | input | VID_W | Idle voltage target code |
| fid_o | output | FID_W | Requested multiplier code |
| vid_o | output | VID_W | Requested voltage code |
| state_o | output | 2 | Controller state (R10 encoding) |

## Verification
Directed sequences aim at a single halted thread, which a design with an OR in place of an AND would wrongly treat as idle. They also cover the exact descent length, which an off-by-one step counter would stretch or shorten. Two kinds of reversal are covered: a wake in the middle of the ramp, and a re-halt in the middle of the climb. A design that reloads the nominal code on reversal would show a jump in vid_o. The settle count is timed after the voltage reaches nominal, which catches a multiplier that returns too early. Random halt and enable patterns then exercise interleaved reversals and mid-ramp disables. They also cover targets at or above nominal, where the block must go straight to low-power. Every cycle is compared against a bench model of the requirements.

// File: rtl/idle_fv_pkg.sv
package idle_fv_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'b00,
    ST_ENTER  = 2'b01,
    ST_LOW    = 2'b10,
    ST_EXIT   = 2'b11
  } pwr_state_e;
endpackage

// File: rtl/idle_fv_detect.sv
module idle_fv_detect #(
  parameter int NUM_THREADS = 2
) (
  input  logic [NUM_THREADS-1:0] halt_i,
  output logic                   all_halt_o
);
  logic [NUM_THREADS:0] chain;
  assign chain[0] = 1'b1;
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_and
    assign chain[t+1] = chain[t] & halt_i[t];
  end
  assign all_halt_o = chain[NUM_THREADS];
endmodule

// File: rtl/idle_fv_timer.sv
module idle_fv_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/idle_fv_vid.sv
module idle_fv_vid #(
  parameter int VID_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VID_W-1:0] vid_nom_i,
  input  logic             dn_i,
  input  logic             up_i,
  output logic [VID_W-1:0] vid_o
);
  logic [VID_W-1:0] vid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vid_q <= '0;
    else if (load_i) vid_q <= vid_nom_i;
    else if (dn_i)   vid_q <= vid_q - VID_W'(1);
    else if (up_i)   vid_q <= vid_q + VID_W'(1);
  end

  assign vid_o = vid_q;

  // R11
  vid_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (vid_q == $past(vid_q) || vid_q == $past(vid_q) + VID_W'(1)
                 || vid_q == $past(vid_q) - VID_W'(1)));
endmodule

// File: rtl/idle_fv_fsm.sv
module idle_fv_fsm
  import idle_fv_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       idle_i,
  input  logic       at_low_i,
  input  logic       at_nom_i,
  input  logic       step_tick_i,
  input  logic       settle_tick_i,
  output pwr_state_e state_o,
  output logic       load_o,
  output logic       dn_o,
  output logic       up_o,
  output logic       step_run_o,
  output logic       settle_run_o
);
  pwr_state_e state_q, state_d;
  logic ramp_dn, ramp_up;

  assign ramp_dn      = en_i && state_q == ST_ENTER && idle_i && !at_low_i;
  assign ramp_up      = en_i && state_q == ST_EXIT && !idle_i && !at_nom_i;
  assign step_run_o   = ramp_dn || ramp_up;
  assign dn_o         = ramp_dn && step_tick_i;
  assign up_o         = ramp_up && step_tick_i;
  assign settle_run_o = en_i && state_q == ST_EXIT && !idle_i && at_nom_i;
  assign load_o       = !en_i || state_q == ST_ACTIVE;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_ACTIVE;
    end else begin
      unique case (state_q)
        ST_ACTIVE: if (idle_i) state_d = ST_ENTER;
        ST_ENTER: begin
          if (!idle_i)       state_d = ST_EXIT;
          else if (at_low_i) state_d = ST_LOW;
        end
        ST_LOW:   if (!idle_i) state_d = ST_EXIT;
        ST_EXIT: begin
          if (idle_i)                         state_d = ST_ENTER;
          else if (at_nom_i && settle_tick_i) state_d = ST_ACTIVE;
        end
        default: state_d = ST_ACTIVE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_ACTIVE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R1
  single_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && en_i && !idle_i) |=> state_q == ST_ACTIVE);
  // R2
  enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && en_i && idle_i) |=> state_q == ST_ENTER);
  // R5
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ENTER || state_q == ST_LOW) && en_i && !idle_i) |=> state_q == ST_EXIT);
  // R6
  settle_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACTIVE && $past(state_q) == ST_EXIT && $past(en_i))
      |-> $past(at_nom_i && settle_tick_i));
  // R7
  disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_ACTIVE);
endmodule

// File: rtl/idle_fv_ctrl.sv
module idle_fv_ctrl
  import idle_fv_pkg::*;
#(
  parameter int NUM_THREADS   = 2,
  parameter int FID_W         = 8,
  parameter int VID_W         = 8,
  parameter int STEP_CYCLES   = 4,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] halt_i,
  input  logic                   enable_i,
  input  logic [FID_W-1:0]       fid_nom_i,
  input  logic [FID_W-1:0]       fid_min_i,
  input  logic [VID_W-1:0]       vid_nom_i,
  input  logic [VID_W-1:0]       vid_low_i,
  output logic [FID_W-1:0]       fid_o,
  output logic [VID_W-1:0]       vid_o,
  output logic [1:0]             state_o
);
  logic             idle, at_low, at_nom;
  logic             step_tick, settle_tick, step_run, settle_run;
  logic             load, dn, up;
  logic [VID_W-1:0] vid_q;
  pwr_state_e       state_q;

  idle_fv_detect #(.NUM_THREADS(NUM_THREADS)) i_detect (
    .halt_i     (halt_i),
    .all_halt_o (idle)
  );

  idle_fv_timer #(.LIMIT(STEP_CYCLES)) i_step_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (step_run), .tick_o (step_tick)
  );

  idle_fv_timer #(.LIMIT(SETTLE_CYCLES)) i_settle_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (settle_run), .tick_o (settle_tick)
  );

  idle_fv_vid #(.VID_W(VID_W)) i_vid (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .vid_nom_i (vid_nom_i),
    .dn_i      (dn),
    .up_i      (up),
    .vid_o     (vid_q)
  );

  assign at_low = vid_q <= vid_low_i;
  assign at_nom = vid_q >= vid_nom_i;

  idle_fv_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (enable_i),
    .idle_i        (idle),
    .at_low_i      (at_low),
    .at_nom_i      (at_nom),
    .step_tick_i   (step_tick),
    .settle_tick_i (settle_tick),
    .state_o       (state_q),
    .load_o        (load),
    .dn_o          (dn),
    .up_o          (up),
    .step_run_o    (step_run),
    .settle_run_o  (settle_run)
  );

  // disable overrides combinationally so nominal is requested the same cycle
  logic nominal;
  assign nominal = !enable_i || state_q == ST_ACTIVE;
  assign fid_o   = nominal ? fid_nom_i : fid_min_i;
  assign vid_o   = nominal ? vid_nom_i : vid_q;
  assign state_o = enable_i ? state_q : ST_ACTIVE;

  // R4
  fid_two_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fid_o == fid_nom_i || fid_o == fid_min_i);
  // R3
  enter_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && state_q == ST_ENTER && vid_low_i < vid_nom_i) |-> vid_q >= vid_low_i);
endmodule

// File: tb/test_idle_fv_ctrl.sv
module test_idle_fv_ctrl;
  localparam int NT = 2, FW = 8, VW = 8, STEP = 3, SETTLE = 5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NT-1:0] halt_i = '0;
  logic          enable_i = 1'b1;
  logic [FW-1:0] fid_nom_i = 8'd36, fid_min_i = 8'd14;
  logic [VW-1:0] vid_nom_i = 8'd40, vid_low_i = 8'd24;
  logic [FW-1:0] fid_o;
  logic [VW-1:0] vid_o;
  logic [1:0]    state_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  idle_fv_ctrl #(.NUM_THREADS(NT), .FID_W(FW), .VID_W(VW),
                 .STEP_CYCLES(STEP), .SETTLE_CYCLES(SETTLE)) i_idle_fv_ctrl (
    .clk_i, .rst_ni, .halt_i, .enable_i, .fid_nom_i, .fid_min_i,
    .vid_nom_i, .vid_low_i, .fid_o, .vid_o, .state_o
  );

  // reference model of the requirements (status codes per R10)
  int m_st, m_vid, m_sc, m_tc;
  always @(posedge clk_i or negedge rst_ni) begin
    automatic bit idle = &halt_i;
    if (!rst_ni) begin
      m_st = 0; m_vid = 0; m_sc = 0; m_tc = 0;
    end else if (!enable_i) begin
      m_st = 0; m_vid = vid_nom_i; m_sc = 0; m_tc = 0;
    end else begin
      case (m_st)
        0: begin m_vid = vid_nom_i; m_sc = 0; m_tc = 0; if (idle) m_st = 1; end
        1: if (!idle) begin m_st = 3; m_sc = 0; end
           else if (m_vid <= vid_low_i) begin m_st = 2; m_sc = 0; end
           else if (m_sc == STEP-1) begin m_vid--; m_sc = 0; end
           else m_sc++;
        2: if (!idle) begin m_st = 3; m_sc = 0; end
        default:
           if (idle) begin m_st = 1; m_sc = 0; m_tc = 0; end
           else if (m_vid < vid_nom_i) begin
             m_tc = 0;
             if (m_sc == STEP-1) begin m_vid++; m_sc = 0; end else m_sc++;
           end else begin
             m_sc = 0;
             if (m_tc == SETTLE-1) begin m_st = 0; m_tc = 0; end else m_tc++;
           end
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_check();
    string tag;
    bit nom = !enable_i || m_st == 0;
    if (!enable_i) tag = "R7";
    else case (m_st)
      0: tag = "R1";
      1: tag = "R3";
      2: tag = "R3";
      default: tag = "R5";
    endcase
    chk("R4", fid_o, nom ? fid_nom_i : fid_min_i, {tag, " fid"});
    chk(tag, vid_o, nom ? vid_nom_i : m_vid, "vid");
    chk("R10", state_o, enable_i ? m_st : 0, {tag, " state"});
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    model_check();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int cnt, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R9", state_o, 0, "reset state");
    chk("R9", fid_o, fid_nom_i, "reset fid");
    chk("R9", vid_o, vid_nom_i, "reset vid");
    rst_ni = 1'b1;
    cyc();

    // R1: one thread halted only
    halt_i = 2'b01;
    repeat (10) cyc();
    halt_i = 2'b10;
    repeat (10) cyc();
    chk("R1", state_o, 0, "single halt state");
    chk("R1", fid_o, fid_nom_i, "single halt fid");

    // R2 / R3: entry and descent length
    halt_i = 2'b11;
    cyc();
    chk("R2", state_o, 1, "entry state");
    chk("R2", fid_o, fid_min_i, "entry fid");
    chk("R2", vid_o, vid_nom_i, "entry vid");
    d = vid_nom_i - vid_low_i;
    cnt = 0;
    while (state_o != 2 && cnt < 1000) begin cyc(); cnt++; end
    chk("R3", cnt, STEP*d + 1, "cycles to low-power");
    chk("R3", vid_o, vid_low_i, "low-power vid");

    // R5: wake from low-power
    halt_i = 2'b10;
    cyc();
    chk("R5", state_o, 3, "wake state");
    chk("R5", vid_o, vid_low_i, "wake vid");
    repeat (STEP-1) cyc();
    chk("R5", vid_o, vid_low_i, "vid before first up step");
    cyc();
    chk("R5", vid_o, vid_low_i + 1, "vid first up step");
    chk("R5", fid_o, fid_min_i, "fid held min while exiting");

    // R8: re-halt mid-climb
    halt_i = 2'b11;
    cyc();
    chk("R8", state_o, 1, "reversal state");
    chk("R8", vid_o, vid_low_i + 1, "reversal vid kept");
    repeat (STEP) cyc();
    chk("R8", vid_o, vid_low_i, "descent continues");

    // R6: settle after voltage back at nominal
    halt_i = 2'b00;
    cnt = 0;
    while (vid_o != vid_nom_i && cnt < 1000) begin cyc(); cnt++; end
    chk("R6", state_o, 3, "exiting at vid nominal");
    chk("R6", fid_o, fid_min_i, "fid still min at vid nominal");
    cnt = 0;
    while (fid_o != fid_nom_i && cnt < 1000) begin cyc(); cnt++; end
    chk("R6", cnt, SETTLE, "settle cycles");
    chk("R6", state_o, 0, "active after settle");

    // R7: disable while in low-power
    halt_i = 2'b11;
    cnt = 0;
    while (state_o != 2 && cnt < 1000) begin cyc(); cnt++; end
    enable_i = 1'b0;
    #1;
    chk("R7", fid_o, fid_nom_i, "fid forced same cycle");
    chk("R7", vid_o, vid_nom_i, "vid forced same cycle");
    chk("R7", state_o, 0, "state forced same cycle");
    repeat (20) cyc();
    chk("R7", state_o, 0, "halts ignored while disabled");
    enable_i = 1'b1;
    halt_i = 2'b00;
    cyc();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      if (enable_i) begin
        if ($urandom_range(299) == 0) enable_i = 1'b0;
      end else if ($urandom_range(9) == 0) begin
        enable_i = 1'b1;
      end else if ($urandom_range(3) == 0) begin
        vid_nom_i = 8'($urandom_range(60, 30));
        vid_low_i = 8'($urandom_range(int'(vid_nom_i) + 2, int'(vid_nom_i) - 20));
      end
      for (int t = 0; t < NT; t++)
        if ($urandom_range(39) == 0) halt_i[t] = ~halt_i[t];
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule